// File: doc/BRIEF.md
# BCD time-of-day transfer sequencer

This block moves a complete date and time between a host-side binary record and a real-time clock chip that stores each value as decimal digits in 4-bit registers. It does not drive the serial wire protocol itself. It issues whole register reads and writes through a simple request/acknowledge nibble port, and a protocol engine below it carries them to the chip. The block also drives the chip-enable line for the whole of each operation.

The host starts one of three operations. The first is a power-up check, which inspects the oscillator-stop flag and re-initialises the chip when that flag is set. The other two are a time read and a time write. Before either time transfer, the sequencer confirms that the chip is not busy, backing off and retrying a bounded number of times. A validity flag records whether the chip's time can be trusted. It is cleared by a failed power-up check, set by a clean check or by a successful time write, and a read made while it is clear fails at once. The host must hold `tm_in` and `wday_in` stable from the start of a write until `done`.

Register map used on the port: the ones digit of field i (i = 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year) sits at address 2i and its tens digit at 2i+1. The weekday is at 12, the timer-interrupt register at 13, the main control register at 14 and the second control register at 15. Bits of the main control register: bit 0 = adjust (write), bit 1 = busy (read), bit 2 = oscillator stopped (read).

Top module: `tod_xfer_seq`

## Requirements
- R1: While reset is active, and right after it is released, `done`, `err`, `reg_ce`, `reg_req` and `time_valid` are all 0.
- R2: A time read or time write starts with a write of `CTRL_CFG` to address 14, followed by a read of address 14. The data transfer begins only when bit 1 (busy) of that read is 0.
- R3: When the busy bit is 1, `reg_ce` is dropped for a back-off of `US_CYCLES` cycles and the attempt pair is repeated. After `GATE_TRIES` (10) busy reads the operation ends with `err`=1.
- R4: A time read issues 13 reads at addresses 0 to 12 in ascending order, ones digit before tens. Field i of `tm_out` (bits 7i+6..7i) becomes tens*10+ones, and `wday_out` takes bits 2..0 of address 12.
- R5: A time write issues 13 writes at addresses 0 to 12 in ascending order. Each field from `tm_in` is split into decimal ones (to 2i) and tens (to 2i+1). The year (field 5) is reduced modulo 100 first, and address 12 receives {0, `wday_in`}.
- R6: In a power-up check, when bit 2 of the first control read is 0, `time_valid` becomes 1 and the operation ends with `err`=0 after that single access.
- R7: In a power-up check, when bit 2 is 1, `time_valid` becomes 0 and the block writes 0 to address 13, then `CTRL_CFG` with bit 0 set to address 14. It then polls address 14 until busy clears, writes `CTRL_CFG` to 14 and `CTRL2_CFG` to 15, and ends with `err`=0.
- R8: If `POLL_TRIES` (1000) consecutive polls see busy, the power-up check ends with `err`=1 and no further writes.
- R9: A time read requested while `time_valid` is 0 ends on the next cycle with `done`=1 and `err`=1, without asserting `reg_ce` or making any access.
- R10: A time write that completes without error sets `time_valid` to 1.
- R11: `reg_ce` is 0 in every cycle where `done` is 1, whether the operation succeeded or failed.
- R12: `done` is a single-cycle pulse, and `err` is valid with it and held until the next operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start a power-up check (priority over `start`) |
| start | input | 1 | Start a time transfer |
| wr_sel | input | 1 | 1 = time write, 0 = time read, sampled with `start` |
| tm_in | input | 42 | Binary fields to write, field i at bits 7i+6..7i |
| wday_in | input | 3 | Weekday to write |
| tm_out | output | 42 | Binary fields from the last read |
| wday_out | output | 3 | Weekday from the last read |
| done | output | 1 | End-of-operation pulse |
| err | output | 1 | Operation failed, valid with `done` |
| time_valid | output | 1 | Chip time is trustworthy |
| reg_ce | output | 1 | Chip enable |
| reg_req | output | 1 | Register access request, held until acknowledged |
| reg_wr | output | 1 | 1 = register write |
| reg_addr | output | 4 | Register address |
| reg_wdata | output | 4 | Write nibble |
| reg_ack | input | 1 | Access complete, read data valid |
| reg_rdata | input | 4 | Read nibble |

## Verification
The assertions check on every cycle that chip enable is low whenever `done` is high and high whenever a request is out, and that chip enable stays low during a busy back-off. They also check that an access request holds its address until acknowledged, that `done` lasts one cycle, that validity rises only on an error-free completion, and that a read of invalid time fails on the very next cycle. The order and content of the register accesses, the decimal split and join of each field with the year wrap, the retry and poll limits, and the exact sequence of the re-initialisation can only be shown by the bench's scenarios against its chip model.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int FW      = 7;           // binary field width
  localparam int NF      = 6;           // sec, min, hour, day, month, year
  localparam int DW      = 4;           // register nibble
  localparam int AW      = 4;           // register address
  localparam int LAST_IX = 2 * NF;      // weekday slot, last of the transfer
  localparam logic [AW-1:0] A_TINT  = 4'd13;
  localparam logic [AW-1:0] A_CTRL  = 4'd14;
  localparam logic [AW-1:0] A_CTRL2 = 4'd15;
  localparam int B_ADJ  = 0;
  localparam int B_BUSY = 1;
  localparam int B_OSC  = 2;

  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_DELAY, S_DONE} state_e;

  typedef enum logic [3:0] {
    P_INIT_RD, P_INIT_TINT, P_INIT_ADJ, P_INIT_POLL, P_INIT_CFG,
    P_INIT_CFG2, P_GATE_WR, P_GATE_RD, P_XFER
  } step_e;

  function automatic logic [FW-1:0] bcd_join(input logic [DW-1:0] tens,
                                             input logic [DW-1:0] ones);
    logic [7:0] acc;
    acc = {4'd0, tens} * 8'd10 + {4'd0, ones};
    return acc[FW-1:0];
  endfunction
endpackage

// File: rtl/tod_bcd_split.sv
module tod_bcd_split #(
  parameter int W      = 7,
  parameter bit MOD100 = 1'b0
) (
  input  logic [W-1:0] bin,
  output logic [3:0]   ones,
  output logic [3:0]   tens
);
  int unsigned vi;

  always_comb begin
    vi = {{(32-W){1'b0}}, bin};
    if (MOD100) vi = vi % 100;
    ones = 4'(vi % 10);
    tens = 4'(vi / 10);
  end
endmodule

// File: rtl/tod_us_timer.sv
module tod_us_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic expired
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d   = cnt_q;
    run_d   = run_q;
    expired = 1'b0;
    if (go) begin
      cnt_d = CW'(CYC - 1);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        expired = 1'b1;
        run_d   = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  a_r3_go_starts_count: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> run_q);
endmodule

// File: rtl/tod_xfer_seq.sv
module tod_xfer_seq import tod_pkg::*; #(
  parameter int          US_CYCLES  = 4,
  parameter int          GATE_TRIES = 10,
  parameter int          POLL_TRIES = 1000,
  parameter logic [3:0]  CTRL_CFG   = 4'b1000,
  parameter logic [3:0]  CTRL2_CFG  = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_req,
  input  logic               start,
  input  logic               wr_sel,
  input  logic [NF*FW-1:0]   tm_in,
  input  logic [2:0]         wday_in,
  output logic [NF*FW-1:0]   tm_out,
  output logic [2:0]         wday_out,
  output logic               done,
  output logic               err,
  output logic               time_valid,
  output logic               reg_ce,
  output logic               reg_req,
  output logic               reg_wr,
  output logic [AW-1:0]      reg_addr,
  output logic [DW-1:0]      reg_wdata,
  input  logic               reg_ack,
  input  logic [DW-1:0]      reg_rdata
);
  localparam int TMAX = (POLL_TRIES > GATE_TRIES) ? POLL_TRIES : GATE_TRIES;
  localparam int TW   = $clog2(TMAX + 1);

  state_e              state_q, state_d;
  step_e               step_q, step_d;
  logic [AW-1:0]       idx_q, idx_d;
  logic [TW-1:0]       tries_q, tries_d;
  logic                ce_q, ce_d, valid_q, valid_d, err_q, err_d;
  logic                opwr_q, opwr_d;
  logic [DW-1:0]       ones_q, ones_d;
  logic [NF*FW-1:0]    out_q, out_d;
  logic [2:0]          wday_q, wday_d;
  logic                tmr_go, tmr_exp;

  // Decimal split of every outgoing field; the year wraps at 100.
  logic [3:0] w_ones [NF];
  logic [3:0] w_tens [NF];
  logic [3:0] wnib   [16];

  for (genvar g = 0; g < NF; g++) begin : g_split
    tod_bcd_split #(.W(FW), .MOD100(g == NF - 1)) u_split (
      .bin (tm_in[g*FW +: FW]),
      .ones(w_ones[g]),
      .tens(w_tens[g])
    );
  end

  always_comb begin
    for (int k = 0; k < 16; k++) wnib[k] = 4'd0;
    for (int f = 0; f < NF; f++) begin
      wnib[2*f]   = w_ones[f];
      wnib[2*f+1] = w_tens[f];
    end
    wnib[LAST_IX] = {1'b0, wday_in};
  end

  tod_us_timer #(.CYC(US_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(tmr_go), .expired(tmr_exp)
  );

  // Access decode for the current step.
  always_comb begin
    reg_addr  = A_CTRL;
    reg_wr    = 1'b0;
    reg_wdata = CTRL_CFG;
    case (step_q)
      P_INIT_TINT: begin reg_addr = A_TINT; reg_wr = 1'b1; reg_wdata = 4'd0; end
      P_INIT_ADJ:  begin reg_wr = 1'b1; reg_wdata = CTRL_CFG | 4'(1 << B_ADJ); end
      P_INIT_CFG,
      P_GATE_WR:   reg_wr = 1'b1;
      P_INIT_CFG2: begin reg_addr = A_CTRL2; reg_wr = 1'b1; reg_wdata = CTRL2_CFG; end
      P_XFER:      begin reg_addr = idx_q; reg_wr = opwr_q; reg_wdata = wnib[idx_q]; end
      default:     ;
    endcase
  end

  // Sequencer next state.
  always_comb begin
    state_d = state_q; step_d = step_q; idx_d = idx_q; tries_d = tries_q;
    ce_d = ce_q; valid_d = valid_q; err_d = err_q; opwr_d = opwr_q;
    ones_d = ones_q; out_d = out_q; wday_d = wday_q; tmr_go = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (init_req) begin
          err_d = 1'b0; ce_d = 1'b1; step_d = P_INIT_RD; state_d = S_ACCESS;
        end else if (start) begin
          err_d = 1'b0; opwr_d = wr_sel;
          if (!wr_sel && !valid_q) begin
            err_d = 1'b1; state_d = S_DONE;
          end else begin
            ce_d = 1'b1; tries_d = '0; step_d = P_GATE_WR; state_d = S_ACCESS;
          end
        end
      end
      S_ACCESS: if (reg_ack) begin
        case (step_q)
          P_INIT_RD: begin
            if (!reg_rdata[B_OSC]) begin
              valid_d = 1'b1; ce_d = 1'b0; state_d = S_DONE;
            end else begin
              valid_d = 1'b0; step_d = P_INIT_TINT;
            end
          end
          P_INIT_TINT: step_d = P_INIT_ADJ;
          P_INIT_ADJ:  begin tries_d = '0; step_d = P_INIT_POLL; end
          P_INIT_POLL: begin
            if (!reg_rdata[B_BUSY]) step_d = P_INIT_CFG;
            else if (tries_q == TW'(POLL_TRIES - 1)) begin
              err_d = 1'b1; ce_d = 1'b0; state_d = S_DONE;
            end else begin
              tries_d = tries_q + 1'b1; tmr_go = 1'b1; state_d = S_DELAY;
            end
          end
          P_INIT_CFG:  step_d = P_INIT_CFG2;
          P_INIT_CFG2: begin ce_d = 1'b0; state_d = S_DONE; end
          P_GATE_WR:   step_d = P_GATE_RD;
          P_GATE_RD: begin
            if (!reg_rdata[B_BUSY]) begin
              idx_d = '0; step_d = P_XFER;
            end else if (tries_q == TW'(GATE_TRIES - 1)) begin
              err_d = 1'b1; ce_d = 1'b0; state_d = S_DONE;
            end else begin
              tries_d = tries_q + 1'b1; ce_d = 1'b0; step_d = P_GATE_WR;
              tmr_go = 1'b1; state_d = S_DELAY;
            end
          end
          default: begin // P_XFER
            if (!opwr_q) begin
              if (idx_q == AW'(LAST_IX)) wday_d = reg_rdata[2:0];
              else if (!idx_q[0])        ones_d = reg_rdata;
              else out_d[int'(idx_q[3:1])*FW +: FW] = bcd_join(reg_rdata, ones_q);
            end
            if (idx_q == AW'(LAST_IX)) begin
              if (opwr_q) valid_d = 1'b1;
              ce_d = 1'b0; state_d = S_DONE;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        endcase
      end
      S_DELAY: if (tmr_exp) begin ce_d = 1'b1; state_d = S_ACCESS; end
      default: state_d = S_IDLE; // S_DONE
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; step_q <= P_INIT_RD; idx_q <= '0; tries_q <= '0;
      ce_q <= 1'b0; valid_q <= 1'b0; err_q <= 1'b0; opwr_q <= 1'b0;
      ones_q <= '0; out_q <= '0; wday_q <= '0;
    end else begin
      state_q <= state_d; step_q <= step_d; idx_q <= idx_d; tries_q <= tries_d;
      ce_q <= ce_d; valid_q <= valid_d; err_q <= err_d; opwr_q <= opwr_d;
      ones_q <= ones_d; out_q <= out_d; wday_q <= wday_d;
    end
  end

  assign done       = (state_q == S_DONE);
  assign err        = err_q;
  assign time_valid = valid_q;
  assign reg_ce     = ce_q;
  assign reg_req    = (state_q == S_ACCESS);
  assign tm_out     = out_q;
  assign wday_out   = wday_q;

  a_r2_req_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> reg_ce);
  a_r2_req_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wr)));
  a_r3_ce_off_in_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DELAY && step_q == P_GATE_WR) |-> !reg_ce);
  a_r9_invalid_read_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !init_req && start && !wr_sel && !valid_q) |=> (done && err && !reg_ce));
  a_r10_valid_rises_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(time_valid) |-> (done && !err));
  a_r11_ce_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !reg_ce);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tod_xfer_seq_bench.sv
module tod_xfer_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, init_req, start, wr_sel;
  logic [41:0] tm_in, tm_out;
  logic [2:0]  wday_in, wday_out;
  logic        done, err, time_valid, reg_ce, reg_req, reg_wr, reg_ack;
  logic [3:0]  reg_addr, reg_wdata, reg_rdata;

  int checks, fails;

  tod_xfer_seq u_tod_xfer_seq (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .start(start), .wr_sel(wr_sel),
    .tm_in(tm_in), .wday_in(wday_in), .tm_out(tm_out), .wday_out(wday_out),
    .done(done), .err(err), .time_valid(time_valid), .reg_ce(reg_ce),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Chip model: 16 nibbles, busy reported on control reads while busy_left > 0.
  logic [3:0] mem [16];
  logic       osc_stop;
  int         busy_left, acc_cnt, ce_rises;
  logic [3:0] log_addr [64];
  logic       log_wr   [64];
  logic [3:0] log_dat  [64];
  logic       ce_prev;

  always @(posedge clk) begin
    if (!rst_n) reg_ack <= 1'b0;
    else if (reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      if (acc_cnt < 64) begin
        log_addr[acc_cnt] <= reg_addr; log_wr[acc_cnt] <= reg_wr; log_dat[acc_cnt] <= reg_wdata;
      end
      acc_cnt <= acc_cnt + 1;
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        if (reg_addr == 4'd14 && reg_wdata[0]) osc_stop <= 1'b0;
      end else if (reg_addr == 4'd14) begin
        reg_rdata <= {mem[14][3], osc_stop, busy_left > 0, 1'b0};
        if (busy_left > 0) busy_left <= busy_left - 1;
      end else reg_rdata <= mem[reg_addr];
    end else reg_ack <= 1'b0;
    ce_prev <= reg_ce;
    if (reg_ce && !ce_prev) ce_rises <= ce_rises + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bcd_val(input int t, input int o);
    return t * 10 + o;
  endfunction

  task automatic run_op(input logic is_init, input logic w, output logic e);
    int n;
    @(negedge clk);
    acc_cnt = 0; ce_rises = 0;
    if (is_init) init_req = 1'b1; else begin start = 1'b1; wr_sel = w; end
    @(negedge clk);
    init_req = 1'b0; start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) chk("R12 done seen", 0, 1);
    e = err;
    chk("R11 ce low at done", int'(reg_ce), 0);
    @(negedge clk);
    chk("R12 done one cycle", int'(done), 0);
    chk("R12 err held", int'(err), int'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic e;
    int   vals [6];
    int   wd;
    void'($urandom(32'd20240611));
    checks = 0; fails = 0;
    init_req = 0; start = 0; wr_sel = 0; tm_in = '0; wday_in = '0;
    busy_left = 0; osc_stop = 1'b1; acc_cnt = 0; ce_rises = 0;
    for (int k = 0; k < 16; k++) mem[k] = 4'd5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 ce in reset", int'(reg_ce), 0);
    chk("R1 req in reset", int'(reg_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err after reset", int'(err), 0);
    chk("R1 valid after reset", int'(time_valid), 0);

    // R9: read while invalid
    run_op(1'b0, 1'b0, e);
    chk("R9 err", int'(e), 1);
    chk("R9 no access", acc_cnt, 0);
    chk("R9 no ce", ce_rises, 0);

    // R7: power-up with oscillator stopped, short busy
    busy_left = 3;
    run_op(1'b1, 1'b0, e);
    chk("R7 err", int'(e), 0);
    chk("R7 valid cleared", int'(time_valid), 0);
    chk("R7 tint cleared", int'(mem[13]), 0);
    chk("R7 adjust addr", int'(log_addr[2]), 14);
    chk("R7 adjust data", int'(log_dat[2]), 9);
    chk("R7 adjust is write", int'(log_wr[2]), 1);
    chk("R7 ctrl final", int'(mem[14]), 8);
    chk("R7 ctrl2 final", int'(mem[15]), 4);

    // R5, R10, R2: random writes
    for (int t = 0; t < 6; t++) begin
      for (int f = 0; f < 6; f++) begin
        vals[f] = (f == 5) ? int'($urandom % 128) : int'($urandom % 100);
        if (t == 0 && f == 5) vals[f] = 123;
        tm_in[f*7 +: 7] = 7'(vals[f]);
      end
      wd = int'($urandom % 7);
      wday_in = 3'(wd);
      run_op(1'b0, 1'b1, e);
      chk("R5 write err", int'(e), 0);
      if (t == 0) begin
        chk("R10 valid set by write", int'(time_valid), 1);
        chk("R2 gate write addr", int'(log_addr[0]), 14);
        chk("R2 gate write data", int'(log_dat[0]), 8);
        chk("R2 gate read", int'(log_wr[1]), 0);
        chk("R2 gate read addr", int'(log_addr[1]), 14);
        chk("R5 access count", acc_cnt, 15);
      end
      for (int f = 0; f < 6; f++) begin
        chk("R5 ones", int'(mem[2*f]), (vals[f] % 100) % 10);
        chk("R5 tens", int'(mem[2*f+1]), (vals[f] % 100) / 10);
      end
      chk("R5 weekday", int'(mem[12]), wd);
    end

    // R4: random reads, including 0 and 99 corners
    for (int t = 0; t < 6; t++) begin
      for (int f = 0; f < 6; f++) begin
        vals[f] = (t == 0) ? 99 : (t == 1) ? 0 : int'($urandom % 100);
        mem[2*f] = 4'(vals[f] % 10); mem[2*f+1] = 4'(vals[f] / 10);
      end
      wd = int'($urandom % 7);
      mem[12] = 4'(wd);
      run_op(1'b0, 1'b0, e);
      chk("R4 read err", int'(e), 0);
      for (int f = 0; f < 6; f++)
        chk("R4 field", int'(tm_out[f*7 +: 7]), bcd_val(vals[f] / 10, vals[f] % 10));
      chk("R4 weekday", int'(wday_out), wd);
      if (t == 0) chk("R4 read addr order", int'(log_addr[14]), 12);
    end

    // R3: busy three times then clear
    busy_left = 3;
    run_op(1'b0, 1'b0, e);
    chk("R3 recovers", int'(e), 0);
    chk("R3 ce attempts", ce_rises, 4);
    chk("R3 access count", acc_cnt, 21);

    // R3: busy on all ten attempts
    busy_left = 10;
    run_op(1'b0, 1'b0, e);
    chk("R3 retry limit err", int'(e), 1);
    chk("R3 retry accesses", acc_cnt, 20);

    // R8: poll timeout
    osc_stop = 1'b1; busy_left = 5000;
    run_op(1'b1, 1'b0, e);
    chk("R8 timeout err", int'(e), 1);
    chk("R8 valid cleared", int'(time_valid), 0);
    chk("R8 poll count", acc_cnt, 1003);
    busy_left = 0;

    // R6: oscillator running
    osc_stop = 1'b0;
    run_op(1'b1, 1'b0, e);
    chk("R6 err", int'(e), 0);
    chk("R6 valid", int'(time_valid), 1);
    chk("R6 single access", acc_cnt, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule